// File: doc/BRIEF.md
# Floating-Point Special-Operand Screen

This block sits in front of a single/double-precision arithmetic unit. For each operation it sorts up to three operands into classes: zero, denormal, normal, infinity, quiet NaN or signalling NaN. It then decides whether the result is forced to a fixed value (default quiet NaN, a signed infinity or zero) or is taken from the datapath result. The datapath result, its status flags and its compare outcome arrive as inputs; this block computes no arithmetic itself.

When the datapath result is used, the block ranks the overflow, underflow and inexact flags by priority. It records the winning flag as a cause and checks the cause against per-cause trap enables. An enabled cause blocks the register write and produces a one-cycle trap request. All outputs are registered, with one cycle of latency. Only round-to-nearest is supported, and denormal datapath results are flushed to zero.

Top module: `fp_special_screen`

## Requirements
- R1: With `dbl`=0 only bits [31:0] of an operand are used (sign 31, exponent 30:23, fraction 22:0). With `dbl`=1 all 64 bits are used (sign 63, exponent 62:52, fraction 51:0). An all-ones exponent with a nonzero fraction is a quiet NaN when the fraction MSB is 1, and a signalling NaN when it is 0.
- R2: A signalling NaN in any operand the operation uses raises invalid (cause bit 4) and forces the default quiet NaN. That value is 0x7FC00000, zero-extended, in single and 0x7FF8000000000000 in double. Operands the operation does not use are ignored: `opb` for rsqrt, and `opc` for everything except the four multiply-add forms.
- R3: Add (op 0) of infinities with opposite signs is invalid. Sub (op 1) of infinities with equal signs is invalid. Any other infinity pairing passes the datapath result through.
- R4: Mul (op 2) of infinity by zero, in either order, is invalid. Div (op 3) of infinity by infinity is invalid, and so is zero by zero.
- R5: Div of a finite nonzero value by zero raises divide-by-zero (cause bit 3). The result is an infinity whose sign is the XOR of the operand signs.
- R6: For multiply-add with product `opa*opb` and addend `opc` (op 5 madd, 6 msub, 7 nmadd, 8 nmsub), infinity times zero is invalid. An infinite product with an infinite addend is invalid for opposite signs in madd and nmsub, and for equal signs in msub and nmadd.
- R7: Rsqrt (op 4) treats its operand as follows:
  - a negative nonzero number or negative infinity is invalid and yields the quiet NaN;
  - a quiet NaN yields the quiet NaN with no cause;
  - positive infinity yields +0;
  - a zero yields an infinity of the same sign and raises divide-by-zero;
  - a positive finite value passes through.
- R8: For pass-through results, only the highest-priority raised datapath flag is recorded as a cause: overflow (bit 2) over underflow (bit 1) over inexact (bit 0). Lower flags are dropped even if their enables are set.
- R9: `trap_req` is high exactly when `cause & trap_en` is nonzero. A trap clears `res_we`, and `trap_req` lasts only for the cycle of that result.
- R10: A pass-through datapath result that is denormal is written as zero with the same sign.
- R11: Compare (op 9) never writes the result. A signalling NaN operand raises invalid and leaves `cc` unchanged. Otherwise `cc` takes `dp_cc`. No other operation changes `cc`.
- R12: Outputs appear one clock after `in_valid`. During reset, and in cycles with no result, `out_valid`, `res_we`, `trap_req` and `cause` are 0. `cc` resets to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation present this cycle |
| op | input | 4 | Operation code |
| dbl | input | 1 | 1 = double precision, 0 = single |
| opa | input | 64 | First operand |
| opb | input | 64 | Second operand |
| opc | input | 64 | Addend for multiply-add forms |
| dp_res | input | 64 | Datapath arithmetic result |
| dp_ovf | input | 1 | Datapath overflow flag |
| dp_unf | input | 1 | Datapath underflow/denormal flag |
| dp_inx | input | 1 | Datapath inexact/rounded flag |
| dp_cc | input | 4 | Datapath compare outcome |
| trap_en | input | 5 | Trap enables, same bit layout as cause |
| out_valid | output | 1 | Result stage valid |
| res | output | 64 | Screened result |
| res_we | output | 1 | Result write enable |
| trap_req | output | 1 | One-cycle trap request |
| cause | output | 5 | Raised cause: 4 V, 3 Z, 2 O, 1 U, 0 I |
| cc | output | 4 | Condition-code field |

## Verification
The bench builds the block with its default package widths: an 8/23 single format and an 11/52 double format inside a 64-bit operand word. These widths bring both precisions within reach from one port set. Single-precision vectors carry garbage in the upper half or a single-format NaN pattern used as a double. This exposes any mix-up of field positions between the two formats. The same vectors also cover each operation's sign rules and the full flag-priority ladder under different enable masks.

// File: rtl/fps_pkg.sv
package fps_pkg;
  localparam int DW      = 64;
  localparam int SW      = 32;
  localparam int SP_EXP  = 8;
  localparam int SP_FRAC = 23;
  localparam int DP_EXP  = 11;
  localparam int DP_FRAC = 52;
  localparam int CAUSE_W = 5;
  localparam int CC_W    = 4;
  localparam int NFLAG   = 3;
  localparam int C_V = 4, C_Z = 3, C_O = 2, C_U = 1, C_I = 0;

  typedef enum logic [2:0] {CL_ZERO, CL_SUB, CL_NORM, CL_INF, CL_QNAN, CL_SNAN} fcls_e;
  typedef enum logic [3:0] {
    OP_ADD = 4'd0, OP_SUB = 4'd1, OP_MUL = 4'd2, OP_DIV = 4'd3, OP_RSQRT = 4'd4,
    OP_MADD = 4'd5, OP_MSUB = 4'd6, OP_NMADD = 4'd7, OP_NMSUB = 4'd8, OP_CMP = 4'd9
  } fop_e;

  typedef struct packed {
    fcls_e cls;
    logic  sign;
  } fdesc_t;

  function automatic logic is_inf(input fdesc_t d);
    return d.cls == CL_INF;
  endfunction
  function automatic logic is_zero(input fdesc_t d);
    return d.cls == CL_ZERO;
  endfunction
  function automatic logic is_nan(input fdesc_t d);
    return (d.cls == CL_QNAN) || (d.cls == CL_SNAN);
  endfunction
  function automatic logic is_finnz(input fdesc_t d);
    return (d.cls == CL_NORM) || (d.cls == CL_SUB);
  endfunction

  function automatic logic [DW-1:0] mk_qnan(input logic dbl);
    return dbl ? {1'b0, {DP_EXP{1'b1}}, 1'b1, {(DP_FRAC-1){1'b0}}}
               : {{SW{1'b0}}, 1'b0, {SP_EXP{1'b1}}, 1'b1, {(SP_FRAC-1){1'b0}}};
  endfunction
  function automatic logic [DW-1:0] mk_inf(input logic dbl, input logic s);
    return dbl ? {s, {DP_EXP{1'b1}}, {DP_FRAC{1'b0}}}
               : {{SW{1'b0}}, s, {SP_EXP{1'b1}}, {SP_FRAC{1'b0}}};
  endfunction
  function automatic logic [DW-1:0] mk_zero(input logic dbl, input logic s);
    return dbl ? {s, {(DW-1){1'b0}}} : {{SW{1'b0}}, s, {(SW-1){1'b0}}};
  endfunction
endpackage

// File: rtl/fps_classify.sv
module fps_classify
  import fps_pkg::*;
(
  input  logic          dbl,
  input  logic [DW-1:0] val,
  output fdesc_t        d
);
  logic e_zero, e_ones, f_zero, q_bit;

  always_comb begin
    if (dbl) begin
      e_zero = ~|val[DW-2 -: DP_EXP];
      e_ones = &val[DW-2 -: DP_EXP];
      f_zero = ~|val[DP_FRAC-1:0];
      q_bit  = val[DP_FRAC-1];
      d.sign = val[DW-1];
    end else begin
      e_zero = ~|val[SW-2 -: SP_EXP];
      e_ones = &val[SW-2 -: SP_EXP];
      f_zero = ~|val[SP_FRAC-1:0];
      q_bit  = val[SP_FRAC-1];
      d.sign = val[SW-1];
    end
    if (e_zero)      d.cls = f_zero ? CL_ZERO : CL_SUB;
    else if (e_ones) d.cls = f_zero ? CL_INF : (q_bit ? CL_QNAN : CL_SNAN);
    else             d.cls = CL_NORM;
  end
endmodule

// File: rtl/fps_rules.sv
module fps_rules
  import fps_pkg::*;
(
  input  fop_e          op,
  input  logic          dbl,
  input  fdesc_t        da,
  input  fdesc_t        db,
  input  fdesc_t        dc,
  output logic          invalid,
  output logic          divz,
  output logic          force_en,
  output logic [DW-1:0] force_val
);
  logic use_b, use_c, snan_any, op_inv, mulzero, prod_inf, prod_sgn;
  logic rs_qnan, rs_pinf;

  always_comb begin
    use_b    = (op != OP_RSQRT);
    use_c    = (op == OP_MADD) || (op == OP_MSUB) || (op == OP_NMADD) || (op == OP_NMSUB);
    snan_any = (da.cls == CL_SNAN) || (use_b && db.cls == CL_SNAN) ||
               (use_c && dc.cls == CL_SNAN);
    mulzero  = (is_inf(da) && is_zero(db)) || (is_zero(da) && is_inf(db));
    prod_inf = (is_inf(da) || is_inf(db)) && !is_zero(da) && !is_zero(db) &&
               !is_nan(da) && !is_nan(db);
    prod_sgn = da.sign ^ db.sign;
    op_inv   = 1'b0;
    divz     = 1'b0;
    rs_qnan  = 1'b0;
    rs_pinf  = 1'b0;
    unique case (op)
      OP_ADD:   op_inv = is_inf(da) && is_inf(db) && (da.sign != db.sign);
      OP_SUB:   op_inv = is_inf(da) && is_inf(db) && (da.sign == db.sign);
      OP_MUL:   op_inv = mulzero;
      OP_DIV: begin
        op_inv = (is_inf(da) && is_inf(db)) || (is_zero(da) && is_zero(db));
        divz   = is_finnz(da) && is_zero(db);
      end
      OP_RSQRT: begin
        op_inv  = da.sign && (is_finnz(da) || is_inf(da));
        rs_qnan = (da.cls == CL_QNAN);
        rs_pinf = is_inf(da) && !da.sign;
        divz    = is_zero(da);
      end
      OP_MADD, OP_NMSUB:
        op_inv = mulzero || (prod_inf && is_inf(dc) && (prod_sgn != dc.sign));
      OP_MSUB, OP_NMADD:
        op_inv = mulzero || (prod_inf && is_inf(dc) && (prod_sgn == dc.sign));
      default:  op_inv = 1'b0;
    endcase
    invalid = snan_any || op_inv;
    if (invalid) divz = 1'b0;

    force_en  = 1'b1;
    if (invalid || rs_qnan) force_val = mk_qnan(dbl);
    else if (divz)          force_val = mk_inf(dbl, (op == OP_DIV) ? prod_sgn : da.sign);
    else if (rs_pinf)       force_val = mk_zero(dbl, 1'b0);
    else begin
      force_en  = 1'b0;
      force_val = '0;
    end
  end
endmodule

// File: rtl/fps_rank.sv
module fps_rank #(
  parameter int N = 3
) (
  input  logic [N-1:0] raise,
  output logic [N-1:0] sel
);
  for (genvar i = 0; i < N; i++) begin : g_pri
    if (i == N-1) begin : g_top
      assign sel[i] = raise[i];
    end else begin : g_low
      assign sel[i] = raise[i] & ~|raise[N-1:i+1];
    end
  end
endmodule

// File: rtl/fp_special_screen.sv
module fp_special_screen
  import fps_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  input  logic [3:0]         op,
  input  logic               dbl,
  input  logic [DW-1:0]      opa,
  input  logic [DW-1:0]      opb,
  input  logic [DW-1:0]      opc,
  input  logic [DW-1:0]      dp_res,
  input  logic               dp_ovf,
  input  logic               dp_unf,
  input  logic               dp_inx,
  input  logic [CC_W-1:0]    dp_cc,
  input  logic [CAUSE_W-1:0] trap_en,
  output logic               out_valid,
  output logic [DW-1:0]      res,
  output logic               res_we,
  output logic               trap_req,
  output logic [CAUSE_W-1:0] cause,
  output logic [CC_W-1:0]    cc
);
  localparam int NCLS = 4;

  fop_e            op_e;
  logic [DW-1:0]   vals [NCLS];
  fdesc_t          descs [NCLS];
  logic            invalid, divz, force_en;
  logic [DW-1:0]   force_val;
  logic [NFLAG-1:0] flag_sel;
  logic [CAUSE_W-1:0] cause_n;
  logic [DW-1:0]   res_n;
  logic            trap_n, we_n, is_cmp;

  assign op_e = fop_e'(op);
  assign vals[0] = opa;
  assign vals[1] = opb;
  assign vals[2] = opc;
  assign vals[3] = dp_res;

  for (genvar k = 0; k < NCLS; k++) begin : g_cls
    fps_classify u_cls (.dbl(dbl), .val(vals[k]), .d(descs[k]));
  end

  fps_rules u_rules (
    .op(op_e), .dbl(dbl), .da(descs[0]), .db(descs[1]), .dc(descs[2]),
    .invalid(invalid), .divz(divz), .force_en(force_en), .force_val(force_val)
  );

  fps_rank #(.N(NFLAG)) u_rank (
    .raise({dp_ovf, dp_unf, dp_inx}), .sel(flag_sel)
  );

  always_comb begin
    is_cmp  = (op_e == OP_CMP);
    cause_n = '0;
    if (invalid)                    cause_n[C_V] = 1'b1;
    else if (divz)                  cause_n[C_Z] = 1'b1;
    else if (!force_en && !is_cmp)  cause_n[C_O:C_I] = flag_sel;
    if (force_en)                   res_n = force_val;
    else if (descs[3].cls == CL_SUB) res_n = mk_zero(dbl, descs[3].sign);
    else                            res_n = dp_res;
    trap_n = |(cause_n & trap_en);
    we_n   = !is_cmp && !trap_n;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      res       <= '0;
      res_we    <= 1'b0;
      trap_req  <= 1'b0;
      cause     <= '0;
      cc        <= '0;
    end else begin
      out_valid <= in_valid;
      res_we    <= in_valid && we_n;
      trap_req  <= in_valid && trap_n;
      cause     <= in_valid ? cause_n : '0;
      if (in_valid) res <= res_n;
      if (in_valid && is_cmp && !invalid) cc <= dp_cc;
    end
  end

  AST_TRAP_BLOCKS_WRITE: assert property (@(posedge clk) disable iff (rst)
    trap_req |-> !res_we);                                               // R9
  AST_TRAP_HAS_CAUSE: assert property (@(posedge clk) disable iff (rst)
    trap_req |-> (cause != '0));                                         // R9
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> (!res_we && !trap_req && cause == '0));               // R12
  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);                                             // R12
  AST_SINGLE_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $onehot0(cause));                                                    // R8
  AST_CC_HOLD: assert property (@(posedge clk) disable iff (rst)
    !$past(in_valid && op == OP_CMP && !rst) |-> $stable(cc));           // R11
endmodule

// File: tb/fp_special_screen_tb.sv
module fp_special_screen_tb;
  localparam int CLK_PERIOD = 10;

  localparam logic [63:0] PINF = 64'h7F800000, NINF = 64'hFF800000;
  localparam logic [63:0] PZ = 64'h0, NZ = 64'h80000000;
  localparam logic [63:0] ONE = 64'h3F800000, NONE = 64'hBF800000;
  localparam logic [63:0] QS = 64'h7FC00000, QN = 64'h7FC00000, SN = 64'h7FA00000;
  localparam logic [63:0] DV = 64'h12345678;
  localparam logic [63:0] DPINF = 64'h7FF0000000000000, DNINF = 64'hFFF0000000000000;
  localparam logic [63:0] DQ = 64'h7FF8000000000000, DONE = 64'h3FF0000000000000;
  localparam logic [63:0] DNZ = 64'h8000000000000000;

  typedef struct packed {
    logic [3:0]  op;
    logic        dbl;
    logic [63:0] a, b, c, dp;
    logic [2:0]  flg;
    logic [4:0]  en;
    logic [63:0] xr;
    logic        xw, xt;
    logic [4:0]  xc;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 40;
  localparam vec_t TBL [NV] = '{
    '{4'd0,1'b0,PINF,NINF,PZ,DV,3'b000,5'h00,QS,1'b1,1'b0,5'h10,8'd3},  // R3
    '{4'd0,1'b0,PINF,PINF,PZ,DV,3'b000,5'h00,DV,1'b1,1'b0,5'h00,8'd3},  // R3
    '{4'd1,1'b0,PINF,PINF,PZ,DV,3'b000,5'h00,QS,1'b1,1'b0,5'h10,8'd3},  // R3
    '{4'd1,1'b0,PINF,NINF,PZ,DV,3'b000,5'h00,DV,1'b1,1'b0,5'h00,8'd3},  // R3
    '{4'd2,1'b0,PINF,NZ,PZ,DV,3'b000,5'h00,QS,1'b1,1'b0,5'h10,8'd4},    // R4
    '{4'd2,1'b0,PZ,PINF,PZ,DV,3'b000,5'h00,QS,1'b1,1'b0,5'h10,8'd4},    // R4
    '{4'd3,1'b0,PINF,NINF,PZ,DV,3'b000,5'h00,QS,1'b1,1'b0,5'h10,8'd4},  // R4
    '{4'd3,1'b0,PZ,NZ,PZ,DV,3'b000,5'h00,QS,1'b1,1'b0,5'h10,8'd4},      // R4
    '{4'd3,1'b0,NONE,PZ,PZ,DV,3'b000,5'h00,NINF,1'b1,1'b0,5'h08,8'd5},  // R5
    '{4'd3,1'b0,ONE,PZ,PZ,DV,3'b000,5'h08,PINF,1'b0,1'b1,5'h08,8'd9},   // R9
    '{4'd0,1'b0,SN,ONE,PZ,DV,3'b000,5'h10,QS,1'b0,1'b1,5'h10,8'd2},     // R2
    '{4'd0,1'b0,ONE,ONE,SN,DV,3'b000,5'h00,DV,1'b1,1'b0,5'h00,8'd2},    // R2
    '{4'd5,1'b0,PINF,ONE,NINF,DV,3'b000,5'h00,QS,1'b1,1'b0,5'h10,8'd6}, // R6
    '{4'd5,1'b0,PINF,ONE,PINF,DV,3'b000,5'h00,DV,1'b1,1'b0,5'h00,8'd6}, // R6
    '{4'd6,1'b0,PINF,ONE,PINF,DV,3'b000,5'h00,QS,1'b1,1'b0,5'h10,8'd6}, // R6
    '{4'd7,1'b0,PINF,ONE,PINF,DV,3'b000,5'h00,QS,1'b1,1'b0,5'h10,8'd6}, // R6
    '{4'd8,1'b0,PINF,ONE,NINF,DV,3'b000,5'h00,QS,1'b1,1'b0,5'h10,8'd6}, // R6
    '{4'd8,1'b0,PINF,ONE,PINF,DV,3'b000,5'h00,DV,1'b1,1'b0,5'h00,8'd6}, // R6
    '{4'd5,1'b0,PZ,PINF,ONE,DV,3'b000,5'h00,QS,1'b1,1'b0,5'h10,8'd6},   // R6
    '{4'd6,1'b0,ONE,ONE,SN,DV,3'b000,5'h00,QS,1'b1,1'b0,5'h10,8'd2},    // R2
    '{4'd4,1'b0,NONE,PZ,PZ,DV,3'b000,5'h00,QS,1'b1,1'b0,5'h10,8'd7},    // R7
    '{4'd4,1'b0,QN,PZ,PZ,DV,3'b000,5'h00,QS,1'b1,1'b0,5'h00,8'd7},      // R7
    '{4'd4,1'b0,PINF,PZ,PZ,DV,3'b000,5'h00,PZ,1'b1,1'b0,5'h00,8'd7},    // R7
    '{4'd4,1'b0,NZ,PZ,PZ,DV,3'b000,5'h00,NINF,1'b1,1'b0,5'h08,8'd7},    // R7
    '{4'd4,1'b0,PZ,PZ,PZ,DV,3'b000,5'h00,PINF,1'b1,1'b0,5'h08,8'd7},    // R7
    '{4'd4,1'b0,NINF,PZ,PZ,DV,3'b000,5'h00,QS,1'b1,1'b0,5'h10,8'd7},    // R7
    '{4'd0,1'b0,ONE,ONE,PZ,DV,3'b100,5'h04,DV,1'b0,1'b1,5'h04,8'd8},    // R8
    '{4'd0,1'b0,ONE,ONE,PZ,DV,3'b101,5'h01,DV,1'b1,1'b0,5'h04,8'd8},    // R8
    '{4'd0,1'b0,ONE,ONE,PZ,DV,3'b011,5'h02,DV,1'b0,1'b1,5'h02,8'd8},    // R8
    '{4'd0,1'b0,ONE,ONE,PZ,DV,3'b001,5'h01,DV,1'b0,1'b1,5'h01,8'd8},    // R8
    '{4'd0,1'b0,ONE,ONE,PZ,DV,3'b010,5'h00,DV,1'b1,1'b0,5'h02,8'd8},    // R8
    '{4'd0,1'b0,ONE,ONE,PZ,64'h00000001,3'b000,5'h00,PZ,1'b1,1'b0,5'h00,8'd10},  // R10
    '{4'd0,1'b0,ONE,ONE,PZ,64'h80000001,3'b000,5'h00,NZ,1'b1,1'b0,5'h00,8'd10},  // R10
    '{4'd0,1'b1,DPINF,DNINF,PZ,DV,3'b000,5'h00,DQ,1'b1,1'b0,5'h10,8'd1},         // R1
    '{4'd4,1'b1,DNZ,PZ,PZ,DV,3'b000,5'h00,DNINF,1'b1,1'b0,5'h08,8'd1},           // R1
    '{4'd3,1'b1,DONE,PZ,PZ,DV,3'b000,5'h00,DPINF,1'b1,1'b0,5'h08,8'd5},          // R5
    '{4'd0,1'b1,DONE,SN,PZ,DONE,3'b000,5'h00,DONE,1'b1,1'b0,5'h00,8'd1},         // R1
    '{4'd0,1'b0,64'h7FF400003F800000,ONE,PZ,DV,3'b000,5'h00,DV,1'b1,1'b0,5'h00,8'd1}, // R1
    '{4'd4,1'b0,ONE,PZ,PZ,DV,3'b000,5'h00,DV,1'b1,1'b0,5'h00,8'd7},     // R7
    '{4'd4,1'b0,ONE,SN,PZ,DV,3'b000,5'h00,DV,1'b1,1'b0,5'h00,8'd2}      // R2
  };

  logic clk = 1'b0, rst = 1'b1, in_valid = 1'b0, dbl = 1'b0;
  logic [3:0] op = '0, dp_cc = '0, cc;
  logic [63:0] opa = '0, opb = '0, opc = '0, dp_res = '0, res;
  logic dp_ovf = 1'b0, dp_unf = 1'b0, dp_inx = 1'b0;
  logic [4:0] trap_en = '0, cause;
  logic out_valid, res_we, trap_req;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fp_special_screen u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op(op), .dbl(dbl),
    .opa(opa), .opb(opb), .opc(opc), .dp_res(dp_res), .dp_ovf(dp_ovf),
    .dp_unf(dp_unf), .dp_inx(dp_inx), .dp_cc(dp_cc), .trap_en(trap_en),
    .out_valid(out_valid), .res(res), .res_we(res_we), .trap_req(trap_req),
    .cause(cause), .cc(cc)
  );

  task automatic chk(input string tag, input string what, input logic [63:0] got,
                     input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
    end
  endtask

  task automatic issue(input logic [3:0] o, input logic d, input logic [63:0] a,
                       input logic [63:0] b, input logic [63:0] c, input logic [63:0] dp,
                       input logic [2:0] f, input logic [4:0] en, input logic [3:0] ccin);
    @(negedge clk);
    op = o; dbl = d; opa = a; opb = b; opc = c; dp_res = dp;
    {dp_ovf, dp_unf, dp_inx} = f; trap_en = en; dp_cc = ccin; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R12", "reset out_valid", {63'b0, out_valid}, 64'd0);
    chk("R12", "reset res_we", {63'b0, res_we}, 64'd0);
    chk("R12", "reset trap", {63'b0, trap_req}, 64'd0);
    chk("R12", "reset cause", {59'b0, cause}, 64'd0);
    chk("R12", "reset cc", {60'b0, cc}, 64'd0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      string tag;
      tag = $sformatf("R%0d vec%0d", TBL[i].req, i);
      issue(TBL[i].op, TBL[i].dbl, TBL[i].a, TBL[i].b, TBL[i].c, TBL[i].dp,
            TBL[i].flg, TBL[i].en, 4'h0);
      chk(tag, "res", res, TBL[i].xr);
      chk(tag, "we", {63'b0, res_we}, {63'b0, TBL[i].xw});
      chk(tag, "trap", {63'b0, trap_req}, {63'b0, TBL[i].xt});
      chk(tag, "cause", {59'b0, cause}, {59'b0, TBL[i].xc});
    end

    // R12 latency and R9 single-cycle trap
    issue(4'd3, 1'b0, ONE, PZ, PZ, DV, 3'b000, 5'h08, 4'h0);
    chk("R12", "valid one cycle after issue", {63'b0, out_valid}, 64'd1);
    chk("R9", "trap with enabled Z", {63'b0, trap_req}, 64'd1);
    @(negedge clk);
    chk("R9", "trap gone next cycle", {63'b0, trap_req}, 64'd0);
    chk("R12", "idle valid", {63'b0, out_valid}, 64'd0);
    chk("R12", "idle cause", {59'b0, cause}, 64'd0);

    // R11 compare behaviour
    issue(4'd9, 1'b0, ONE, ONE, PZ, DV, 3'b000, 5'h00, 4'h2);
    chk("R11", "cmp cc load", {60'b0, cc}, 64'h2);
    chk("R11", "cmp no write", {63'b0, res_we}, 64'd0);
    chk("R11", "cmp no cause", {59'b0, cause}, 64'd0);
    issue(4'd9, 1'b0, SN, ONE, PZ, DV, 3'b000, 5'h00, 4'h8);
    chk("R11", "cmp snan keeps cc", {60'b0, cc}, 64'h2);
    chk("R11", "cmp snan cause V", {59'b0, cause}, 64'h10);
    chk("R11", "cmp snan no write", {63'b0, res_we}, 64'd0);
    issue(4'd9, 1'b0, ONE, SN, PZ, DV, 3'b000, 5'h10, 4'h8);
    chk("R9", "cmp snan trap when V enabled", {63'b0, trap_req}, 64'd1);
    issue(4'd0, 1'b0, ONE, ONE, PZ, DV, 3'b000, 5'h00, 4'h4);
    chk("R11", "non-compare leaves cc", {60'b0, cc}, 64'h2);
    issue(4'd9, 1'b0, ONE, ONE, PZ, DV, 3'b111, 5'h1F, 4'h1);
    chk("R11", "cmp ignores flags", {59'b0, cause}, 64'd0);
    chk("R11", "cmp cc update", {60'b0, cc}, 64'h1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, got timeout expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule